// File: doc/BRIEF.md
# Dual-Slot Edge Capture Unit

This block records when an external pin changes, measured against a free-running counter that lives outside it. The pin is first passed through a chain of synchronising flops. The settled level is then compared with the level from the cycle before, which picks out rising and falling edges. Each edge that matches the configured mode places the counter value into one of two capture slots. The first qualifying edge fills slot 0 and the next one fills slot 1. After that, further edges are dropped until software re-arms the unit.

A single-cycle event pulse tells the surrounding logic that a measurement is ready. A select bit chooses whether the pulse follows the first capture or the second. Re-arming sets the fill position back to slot 0. Two actions re-arm the unit: a capture-status clear strobe, or a mode write that moves the unit out of the disabled mode. The mode is held in a register that loads `cfg_mode_i` only while the mode-write strobe is high. The second-capture select and the pin-direction bit take effect immediately.

Top module: `dual_slot_capture`

## Requirements
- R1: After reset both capture slots read 0, the event output is low and the held mode is disabled (code 0).
- R2: While the held mode is 0 (disabled), no pin activity changes either slot.
- R3: With mode code 1 only a low-to-high transition of the synchronised pin is captured. High-to-low transitions change nothing.
- R4: With mode code 2 only a high-to-low transition is captured.
- R5: With mode code 3 transitions in both directions are captured.
- R6: While `cfg_dir_in_i` is 0 (pin not an input), edges are not captured and the fill position does not advance.
- R7: Qualifying edges fill slot 0 first and slot 1 second. Any edge after both slots are full leaves both slots unchanged.
- R8: With `cfg_second_i` = 0, `cap_evt_o` pulses for exactly one cycle when slot 0 is written, and does not pulse when slot 1 is written.
- R9: With `cfg_second_i` = 1, `cap_evt_o` pulses for exactly one cycle when slot 1 is written, and does not pulse when slot 0 is written.
- R10: A mode write that changes the held mode from 0 to any non-zero code returns the fill position to slot 0.
- R11: A pulse on `clr_i` returns the fill position to slot 0. In that cycle no capture happens.
- R12: Suppose a pin change is first sampled at clock edge k. Then the slot takes the `count_i` value present at edge k+2, and `cap_evt_o` (when due) is high in the cycle after edge k+2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| count_i | input | CW | Free-running counter value to be sampled |
| pin_i | input | 1 | Asynchronous external pin |
| cfg_mode_i | input | 2 | Edge mode: 0 off, 1 rising, 2 falling, 3 both; loaded on cfg_wr_i |
| cfg_second_i | input | 1 | 0: event after first capture, 1: event after second |
| cfg_dir_in_i | input | 1 | 1 when the pin is configured as an input |
| cfg_wr_i | input | 1 | Mode-write strobe |
| clr_i | input | 1 | Capture-status clear strobe; re-arms the slots |
| cap0_o | output | CW | First capture slot |
| cap1_o | output | CW | Second capture slot |
| cap_evt_o | output | 1 | Single-cycle capture event |

## Verification
A fill position that is wrong shows up at the next qualifying edge. The counter value either lands in the wrong slot, or it is dropped when it should be taken. The event pulse then also comes one capture early or late, or not at all. A wrong synchroniser or edge-history state shows up two cycles after a pin change: the slot gets a different counter value, or an edge of the wrong direction is accepted. Because the bench model is compared on every clock, any such divergence is reported in the cycle it first reaches the slot registers or the event output.

// File: rtl/cap_pkg.sv
package cap_pkg;

    typedef enum logic [1:0] {
        CAP_OFF  = 2'd0,
        CAP_RISE = 2'd1,
        CAP_FALL = 2'd2,
        CAP_BOTH = 2'd3
    } cap_mode_e;

endpackage

// File: rtl/cap_sync.sv
module cap_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic level_o
);
    logic [STAGES-1:0] chain_d, chain_q;

    generate
        if (STAGES == 1) begin : g_single
            always_comb chain_d = async_i;
        end else begin : g_multi
            always_comb chain_d = {chain_q[STAGES-2:0], async_i};
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign level_o = chain_q[STAGES-1];
endmodule

// File: rtl/cap_edge_detect.sv
module cap_edge_detect
    import cap_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      level_i,
    input  cap_mode_e mode_i,
    output logic      hit_o
);
    logic prev_d, prev_q;
    logic rise, fall;

    always_comb begin
        prev_d = level_i;
        rise   = level_i & ~prev_q;
        fall   = ~level_i & prev_q;
        unique case (mode_i)
            CAP_OFF:  hit_o = 1'b0;
            CAP_RISE: hit_o = rise;
            CAP_FALL: hit_o = fall;
            CAP_BOTH: hit_o = rise | fall;
            default:  hit_o = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= prev_d;
    end
endmodule

// File: rtl/dual_slot_capture.sv
module dual_slot_capture
    import cap_pkg::*;
#(
    parameter int CW          = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] count_i,
    input  logic          pin_i,
    input  logic [1:0]    cfg_mode_i,
    input  logic          cfg_second_i,
    input  logic          cfg_dir_in_i,
    input  logic          cfg_wr_i,
    input  logic          clr_i,
    output logic [CW-1:0] cap0_o,
    output logic [CW-1:0] cap1_o,
    output logic          cap_evt_o
);
    localparam int SLOTS = 2;
    localparam int IDXW  = $clog2(SLOTS + 1);

    typedef struct packed {
        logic [IDXW-1:0]           idx;
        cap_mode_e                 mode;
        logic                      evt;
        logic [SLOTS-1:0][CW-1:0]  cap;
    } cap_state_t;

    cap_state_t d, q;
    logic       sync_level;
    logic       edge_hit;
    logic       rearm;
    logic       take;

    cap_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (pin_i),
        .level_o (sync_level)
    );

    cap_edge_detect u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .level_i (sync_level),
        .mode_i  (q.mode),
        .hit_o   (edge_hit)
    );

    always_comb begin
        d     = q;
        d.evt = 1'b0;
        rearm = clr_i || (cfg_wr_i && (q.mode == CAP_OFF) && (cfg_mode_i != 2'd0));
        take  = edge_hit && cfg_dir_in_i && (q.idx < IDXW'(SLOTS));
        if (cfg_wr_i) d.mode = cap_mode_e'(cfg_mode_i);
        if (rearm) begin
            d.idx = '0;
        end else if (take) begin
            for (int s = 0; s < SLOTS; s++) begin
                if (q.idx == IDXW'(s)) d.cap[s] = count_i;
            end
            d.idx = q.idx + 1'b1;
            d.evt = (q.idx == IDXW'(cfg_second_i));
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.idx  <= '0;
            q.mode <= CAP_OFF;
            q.evt  <= 1'b0;
            q.cap  <= '0;
        end else begin
            q <= d;
        end
    end

    assign cap0_o    = q.cap[0];
    assign cap1_o    = q.cap[1];
    assign cap_evt_o = q.evt;
endmodule

// File: rtl/dual_slot_capture_chk.sv
module dual_slot_capture_chk #(
    parameter int CW   = 32,
    parameter int IDXW = 2
) (
    input logic            clk,
    input logic            rst_n,
    input logic [CW-1:0]   cap0_o,
    input logic [CW-1:0]   cap1_o,
    input logic            cap_evt_o,
    input logic            cfg_dir_in_i,
    input logic            cfg_second_i,
    input logic            cfg_wr_i,
    input logic [1:0]      cfg_mode_i,
    input logic            clr_i,
    input logic [IDXW-1:0] idx_q,
    input logic [1:0]      mode_q
);
    AST_OFF_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == 2'd0) |=> ($stable(cap0_o) && $stable(cap1_o))); // R2

    AST_DIR_OUT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_dir_in_i |=> ($stable(cap0_o) && $stable(cap1_o) && $stable(idx_q))); // R6

    AST_IDX_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        idx_q <= IDXW'(2)); // R7

    AST_ONE_SLOT_PER_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cap1_o) |-> $stable(cap0_o)); // R7

    AST_EVT_SLOT_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        cap_evt_o |-> ($past(idx_q) == IDXW'($past(cfg_second_i)))); // R8

    AST_CLR_REARMS: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (idx_q == '0)); // R11

    AST_ENABLE_REARMS: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr_i && mode_q == 2'd0 && cfg_mode_i != 2'd0) |=> (idx_q == '0)); // R10
endmodule

bind dual_slot_capture dual_slot_capture_chk #(.CW(CW), .IDXW(IDXW)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cap0_o       (cap0_o),
    .cap1_o       (cap1_o),
    .cap_evt_o    (cap_evt_o),
    .cfg_dir_in_i (cfg_dir_in_i),
    .cfg_second_i (cfg_second_i),
    .cfg_wr_i     (cfg_wr_i),
    .cfg_mode_i   (cfg_mode_i),
    .clr_i        (clr_i),
    .idx_q        (q.idx),
    .mode_q       (q.mode)
);

// File: tb/dual_slot_capture_tb.sv
`timescale 1ns/1ps
module dual_slot_capture_tb;
    localparam int CW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [CW-1:0] count_i = '0;
    logic          pin_i = 1'b0;
    logic [1:0]    cfg_mode_i = 2'd0;
    logic          cfg_second_i = 1'b0;
    logic          cfg_dir_in_i = 1'b0;
    logic          cfg_wr_i = 1'b0;
    logic          clr_i = 1'b0;
    logic [CW-1:0] cap0_o, cap1_o;
    logic          cap_evt_o;

    int n_run = 0;
    int n_fail = 0;
    bit done = 0;

    always #2 clk = ~clk;

    dual_slot_capture #(.CW(CW)) u_dut (
        .clk(clk), .rst_n(rst_n), .count_i(count_i), .pin_i(pin_i),
        .cfg_mode_i(cfg_mode_i), .cfg_second_i(cfg_second_i),
        .cfg_dir_in_i(cfg_dir_in_i), .cfg_wr_i(cfg_wr_i), .clr_i(clr_i),
        .cap0_o(cap0_o), .cap1_o(cap1_o), .cap_evt_o(cap_evt_o)
    );

    // behavioural reference
    logic          m_s1, m_s2, m_pv;
    int            m_mode, m_idx;
    logic [CW-1:0] m_c0, m_c1;
    logic          m_evt;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_s1 = 0; m_s2 = 0; m_pv = 0;
            m_mode = 0; m_idx = 0; m_c0 = 0; m_c1 = 0; m_evt = 0;
        end else begin
            bit hit, rearm;
            hit = (m_mode == 1 && m_s2 && !m_pv) || (m_mode == 2 && !m_s2 && m_pv) ||
                  (m_mode == 3 && m_s2 != m_pv);
            rearm = clr_i || (cfg_wr_i && m_mode == 0 && cfg_mode_i != 0);
            m_evt = 0;
            if (rearm) m_idx = 0;
            else if (hit && cfg_dir_in_i && m_idx < 2) begin
                if (m_idx == 0) m_c0 = count_i; else m_c1 = count_i;
                m_evt = (m_idx == int'(cfg_second_i));
                m_idx++;
            end
            if (cfg_wr_i) m_mode = int'(cfg_mode_i);
            m_pv = m_s2; m_s2 = m_s1; m_s1 = pin_i;
        end
    end

    task automatic chk(string tag, logic [CW-1:0] act, logic [CW-1:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
        count_i = count_i + 1;
        if (rst_n) begin
            chk("R7 model slot0", cap0_o, m_c0);
            chk("R7 model slot1", cap1_o, m_c1);
            chk("R8 model event", {31'b0, cap_evt_o}, {31'b0, m_evt});
        end
    endtask

    // returns counter value expected in the slot (R12)
    task automatic pin_to(input logic v, output logic [CW-1:0] exp_val);
        pin_i = v;
        exp_val = count_i + 2;
        step(); step(); step();
    endtask

    task automatic write_mode(input logic [1:0] m);
        cfg_mode_i = m; cfg_wr_i = 1'b1;
        step();
        cfg_wr_i = 1'b0;
    endtask

    task automatic pulse_clr();
        clr_i = 1'b1; step(); clr_i = 1'b0;
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [CW-1:0] e0, e1, ex;
        count_i = 32'h100;
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        // R1
        chk("R1 slot0 reset", cap0_o, '0);
        chk("R1 slot1 reset", cap1_o, '0);
        chk("R1 event reset", {31'b0, cap_evt_o}, '0);
        step();

        // R2: disabled mode, input direction
        cfg_dir_in_i = 1'b1;
        pin_to(1, ex); pin_to(0, ex);
        chk("R2 off no capture", cap0_o, '0);

        // R6: rising mode but pin not input
        write_mode(2'd1);
        cfg_dir_in_i = 1'b0;
        pin_to(1, ex); pin_to(0, ex);
        chk("R6 dir out no capture", cap0_o, '0);
        step();

        // R3 R8 R12: rising, event after first
        cfg_dir_in_i = 1'b1; cfg_second_i = 1'b0;
        pin_to(1, e0);
        chk("R12 slot0 sampled value", cap0_o, e0);
        chk("R8 event on first", {31'b0, cap_evt_o}, 32'd1);
        pin_to(0, ex);
        chk("R3 falling ignored", cap1_o, '0);
        chk("R8 no event", {31'b0, cap_evt_o}, '0);
        pin_to(1, e1);
        chk("R3 rising into slot1", cap1_o, e1);
        chk("R8 no event on second", {31'b0, cap_evt_o}, '0);
        pin_to(0, ex); pin_to(1, ex);
        chk("R7 full slot0 kept", cap0_o, e0);
        chk("R7 full slot1 kept", cap1_o, e1);

        // R11 R4: clear, falling mode (non-zero to non-zero write)
        pulse_clr();
        write_mode(2'd2);
        pin_to(0, e0);
        chk("R4 R11 falling into slot0", cap0_o, e0);
        pin_to(1, ex);
        chk("R4 rising ignored", cap1_o, e1);

        // R10 R5 R9: off then both, event after second
        write_mode(2'd0);
        write_mode(2'd3);
        cfg_second_i = 1'b1;
        pin_to(0, e0);
        chk("R5 R10 falling into slot0", cap0_o, e0);
        chk("R9 no event on first", {31'b0, cap_evt_o}, '0);
        pin_to(1, e1);
        chk("R5 rising into slot1", cap1_o, e1);
        chk("R9 event on second", {31'b0, cap_evt_o}, 32'd1);
        step();
        chk("R9 pulse single cycle", {31'b0, cap_evt_o}, '0);

        // R10 negative: non-zero to non-zero write does not re-arm
        write_mode(2'd2);
        pin_to(0, ex);
        chk("R10 no re-arm slot0", cap0_o, e0);
        chk("R10 no re-arm slot1", cap1_o, e1);

        // R11: clear same cycle as an edge drops that edge
        pin_i = 1'b1; step(); step(); step(); step();
        pin_i = 1'b0; step(); step();
        clr_i = 1'b1; step(); clr_i = 1'b0;
        step(); step();
        chk("R11 edge lost under clear", cap0_o, e0);

        repeat (4) step();
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule